// File: doc/BRIEF.md
# Asynchronous PSRAM Access Controller

This block sits between a synchronous host and an external asynchronous pseudo-static RAM with a 20-bit word address and a 16-bit shared data bus. The host offers one word or byte access at a time on a request/acknowledge port: address, write data, a per-byte select mask and a direction bit. The controller then drives the RAM strobes (chip enable, output enable, write enable and one select per byte lane, all active low), drives the data bus only while writing, and captures the read data.

Every analog timing limit of the RAM is a nanosecond parameter. At elaboration it becomes a clock-cycle count by rounding up against the clock period. The RAM refreshes itself in the background, so it limits how long a cycle may last in both directions. The controller therefore always ends an access and raises chip enable after a fixed number of cycles. That count stays well under the one-microsecond ceiling on a held address.

The data pad is outside the block. It is reached through a separate output value, an output-enable and an input value.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is low and after it, until the first request, all five strobes are high, the data bus is not driven and `ack` is low.
- R2: A read first presents the address for one cycle with output enable high and the bus released. Chip enable and output enable then fall together and stay low for exactly RD_CYC cycles (9 at 8 ns). That window covers the 70 ns access, the 45 ns output-enable access and the 80 ns cycle minimum.
- R3: Read data is sampled on the clock edge that closes the read window. `ack` is high for exactly one cycle after that edge, on the 10th rising edge after the edge that accepted the request.
- R4: A write lowers chip enable, write enable and the selected byte strobes on the accepting edge. They stay low for exactly WP_CYC cycles (9), which is at least 65 ns and far below 1000 ns.
- R5: The data bus is driven only from the start of the write pulse to the end of write recovery. It is never driven while output enable is low.
- R6: After a write pulse the address and data stay put for REC_CYC cycles (2, at least 15 ns) with all strobes high. `ack` then pulses, on the 11th rising edge after acceptance, so pulse plus recovery is at least 80 ns.
- R7: Chip enable stays high for at least GAP_CYC cycles (2, at least 15 ns) between any two accesses.
- R8: Mask bit 0 selects data bits 7:0 through the lower strobe, and mask bit 1 selects bits 15:8 through the upper strobe. A deselected lane keeps its strobe high, so a write with mask 00 changes no RAM content. On a read, deselected lanes of `rdata` return zero.
- R9: Output enable is high whenever write enable is low, including the cycle in which a write address first appears.
- R10: A request is taken only when the controller is idle. A `req_valid` pulse during an access is dropped: it yields no access and no `ack`.
- R11: Chip enable is never held low on one unchanged address for 1 µs or more (125 cycles at 8 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data, valid while `ack` is high |
| mem_addr | output | 20 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_byte_n | output | 2 | RAM byte strobes, bit 0 lower, bit 1 upper, active low |
| mem_dq_out | output | 16 | Value driven onto the data pad |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_in | input | 16 | Value read from the data pad |

## Verification
Taking the request edge as zero, a read's `ack` and data are due after rising edge 10 and a write's `ack` after edge 11. Strobe edges fall on the accepting edge for writes and on the next edge for reads. The driver stamps each request with the cycle count at issue. The scoreboard checks the stamp difference exactly against these figures when it pops the item. All pin observations are taken on the falling clock edge. A pin monitor measures the read window, write pulse and chip-enable gap in whole cycles and compares them with the derived counts.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
// psram_pkg: shared sequencer state type and the helpers that turn
// nanosecond limits into clock-cycle counts at elaboration.
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for a request, all strobes high
        ST_RD_SETUP,  // read address presented, bus released
        ST_RD_ACT,    // chip and output enable low, data settling
        ST_WR_PULSE,  // chip, write and byte enables low, data driven
        ST_WR_REC,    // strobes high, address and data held
        ST_CE_GAP     // chip enable high before the next access
    } seq_state_t;

    // Round a time up to whole clock cycles, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_timer.sv
`timescale 1ns/1ps
// psram_timer: load-and-count-down cycle timer for the sequencer.
// Assumes the loaded value is the number of cycles to stay minus one,
// so a state that loads N-1 on entry leaves after N cycles.
module psram_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/psram_seq.sv
`timescale 1ns/1ps
// psram_seq: access state machine. It steps through the read and write
// phases and registers the control strobes from the next state, so each
// pin changes on the same edge as the state. Assumes every cycle count
// is at least one.
module psram_seq
    import psram_pkg::*;
#(
    parameter int unsigned RD_CYC  = 9,
    parameter int unsigned WP_CYC  = 9,
    parameter int unsigned REC_CYC = 2,
    parameter int unsigned GAP_CYC = 2,
    parameter int unsigned CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             bsel_nxt,
    output logic             ack,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REC = CNT_W'(REC_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP = CNT_W'(GAP_CYC - 1);

    seq_state_t st, st_n;
    logic       wr_done;

    // Next-state, timer reload and completion events.
    always_comb begin
        st_n     = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        wr_done  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        st_n     = ST_WR_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_WP;
                    end else begin
                        st_n = ST_RD_SETUP;
                    end
                end
            end
            ST_RD_SETUP: begin
                st_n     = ST_RD_ACT;
                tmr_load = 1'b1;
                tmr_val  = LD_RD;
            end
            ST_RD_ACT: begin
                if (tmr_zero) begin
                    capture  = 1'b1;
                    st_n     = ST_CE_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_GAP;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    st_n     = ST_WR_REC;
                    tmr_load = 1'b1;
                    tmr_val  = LD_REC;
                end
            end
            ST_WR_REC: begin
                if (tmr_zero) begin
                    wr_done = 1'b1;
                    st_n    = ST_IDLE;
                end
            end
            ST_CE_GAP: begin
                if (tmr_zero) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Byte strobes are active whenever chip enable will be low.
    assign bsel_nxt = (st_n == ST_RD_ACT) || (st_n == ST_WR_PULSE);

    // State register and strobe registers decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            ack   <= 1'b0;
        end else begin
            st    <= st_n;
            ce_n  <= !bsel_nxt;
            oe_n  <= (st_n != ST_RD_ACT);
            we_n  <= (st_n != ST_WR_PULSE);
            dq_oe <= (st_n == ST_WR_PULSE) || (st_n == ST_WR_REC);
            ack   <= capture | wr_done;
        end
    end

endmodule

// File: rtl/psram_lanes.sv
`timescale 1ns/1ps
// psram_lanes: address, write data and byte-mask holding registers, the
// per-lane byte strobes and the lane-masked read capture. Assumes the
// data width is a whole number of bytes.
module psram_lanes #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              bsel_nxt,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [LANES-1:0]  mem_byte_n,
    output logic [DATA_W-1:0] rdata
);

    logic [LANES-1:0] mask_q;
    logic [LANES-1:0] mask_nxt;

    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mask_q     <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            mask_q     <= req_be;
        end
    end

    assign mask_nxt = accept ? req_be : mask_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Byte strobe of this lane, low only inside an access it takes part in.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_byte_n[g] <= 1'b1;
            end else begin
                mem_byte_n[g] <= !(bsel_nxt && mask_nxt[g]);
            end
        end

        // Read capture of this lane, zero when the lane is not selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[g*8 +: 8] <= '0;
            end else if (capture) begin
                rdata[g*8 +: 8] <= mask_q[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/psram_ctrl.sv
`timescale 1ns/1ps
// psram_ctrl: host-side controller for an asynchronous pseudo-static RAM.
// Turns the nanosecond limits into cycle counts, then runs one access per
// request. Assumes the pad logic outside merges mem_dq_out/mem_dq_oe/
// mem_dq_in into the shared bus and that the host offers a request only
// while it expects the controller to be idle.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned CLK_NS     = 8,
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned T_ACC_NS   = 70,
    parameter int unsigned T_OE_NS    = 45,
    parameter int unsigned T_CYCLE_NS = 80,
    parameter int unsigned T_WP_NS    = 65,
    parameter int unsigned T_REC_NS   = 15,
    parameter int unsigned T_CEH_NS   = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  ack,
    output logic [DATA_W-1:0]     rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [DATA_W/8-1:0]   mem_byte_n,
    output logic [DATA_W-1:0]     mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_in
);

    localparam int unsigned LANES   = DATA_W / 8;
    // Read window: chip/output enable access and the cycle minimum, less the setup cycle.
    localparam int unsigned RD_CYC  = max_u(max_u(ns_to_cyc(T_ACC_NS, CLK_NS),
                                                  ns_to_cyc(T_OE_NS, CLK_NS)),
                                            ns_to_cyc(T_CYCLE_NS, CLK_NS) - 1);
    localparam int unsigned WP_CYC  = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned REC_CYC = max_u(ns_to_cyc(T_REC_NS, CLK_NS),
                                            max_u(ns_to_cyc(T_CYCLE_NS, CLK_NS), WP_CYC + 1) - WP_CYC);
    localparam int unsigned GAP_CYC = ns_to_cyc(T_CEH_NS, CLK_NS);
    localparam int unsigned LD_MAX  = max_u(max_u(RD_CYC, WP_CYC), max_u(REC_CYC, GAP_CYC));
    localparam int unsigned CNT_W   = $clog2(LD_MAX + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             accept;
    logic             capture;
    logic             bsel_nxt;

    psram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    psram_seq #(
        .RD_CYC  (RD_CYC),
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC),
        .GAP_CYC (GAP_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .bsel_nxt  (bsel_nxt),
        .ack       (ack),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dq_oe     (mem_dq_oe)
    );

    psram_lanes #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .bsel_nxt   (bsel_nxt),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_byte_n (mem_byte_n),
        .rdata      (rdata)
    );

endmodule

// File: rtl/psram_ctrl_chk.sv
`timescale 1ns/1ps
// psram_ctrl_chk: timing and protocol properties on the RAM-side pins,
// attached to every psram_ctrl instance. Window lengths are tracked with
// counters so no property depends on a parameter-sized delay.
module psram_ctrl_chk
    import psram_pkg::*;
#(
    parameter int unsigned CLK_NS     = 8,
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned LANES      = 2,
    parameter int unsigned T_WP_NS    = 65,
    parameter int unsigned T_CEH_NS   = 15,
    parameter int unsigned T_HOLD_MAX = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ce_n,
    input  logic              mem_oe_n,
    input  logic              mem_we_n,
    input  logic [LANES-1:0]  mem_byte_n,
    input  logic              mem_dq_oe,
    input  logic              ack
);

    localparam int unsigned CAP_CYC = T_HOLD_MAX / CLK_NS;
    localparam int unsigned WP_CYC  = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned GAP_CYC = ns_to_cyc(T_CEH_NS, CLK_NS);
    localparam int unsigned RUN_W   = $clog2(CAP_CYC + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_SAT = '1;

    logic [ADDR_W-1:0] addr_prev;
    logic [RUN_W-1:0]  ce_run;
    logic [RUN_W-1:0]  we_run;
    logic [RUN_W-1:0]  ceh_run;

    // Track how long chip enable has been low on one address, write enable
    // low, and chip enable high (the last starts saturated after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_prev <= '0;
            ce_run    <= '0;
            we_run    <= '0;
            ceh_run   <= RUN_SAT;
        end else begin
            addr_prev <= mem_addr;
            if (mem_ce_n) begin
                ce_run <= '0;
            end else if (ce_run != '0 && mem_addr == addr_prev) begin
                ce_run <= (ce_run == RUN_SAT) ? ce_run : ce_run + 1'b1;
            end else begin
                ce_run <= RUN_W'(1);
            end
            we_run  <= mem_we_n ? '0 : ((we_run == RUN_SAT) ? we_run : we_run + 1'b1);
            ceh_run <= !mem_ce_n ? '0 : ((ceh_run == RUN_SAT) ? ceh_run : ceh_run + 1'b1);
        end
    end

    AST_NO_OE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R9
    AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && mem_dq_oe)); // R5
    AST_RELEASE_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R2
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R3
    AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> we_run >= RUN_W'(WP_CYC)); // R4
    AST_REC_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |=> $stable(mem_addr)); // R6
    AST_CE_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> ceh_run >= RUN_W'(GAP_CYC)); // R7
    AST_BYTE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (&mem_byte_n)); // R8
    AST_CE_HOLD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ce_run < RUN_W'(CAP_CYC)); // R11

endmodule

bind psram_ctrl psram_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_byte_n (mem_byte_n),
    .mem_dq_oe  (mem_dq_oe),
    .ack        (ack)
);

// File: tb/tb_psram_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected completions, the monitor
// pops them on each ack and also measures the RAM strobe windows.
module tb_psram_ctrl;

    localparam int RD_CYC  = 9;
    localparam int WP_CYC  = 9;
    localparam int REC_CYC = 2;
    localparam int GAP_CYC = 2;
    localparam int CAP_CYC = 125;
    localparam int RD_LAT  = 2 + RD_CYC;        // issue negedge to ack negedge
    localparam int WR_LAT  = 1 + WP_CYC + REC_CYC + 0 + 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_byte_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    psram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_byte_n(mem_byte_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [15:0] exp;
        logic [31:0] issue;
    } item_t;

    item_t       q[$];
    logic [15:0] ram [0:255];
    logic [15:0] shadow [0:255];
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    logic [1:0]  cur_be = '0;

    function automatic logic [15:0] init_word(input int i);
        return 16'h5A00 ^ {8'(i), ~8'(i)};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // RAM model read path: deselected or idle lanes show a filler byte.
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            mem_dq_in[i*8 +: 8] = (!mem_ce_n && !mem_oe_n && !mem_byte_n[i])
                                  ? ram[mem_addr[7:0]][i*8 +: 8] : 8'hEE;
        end
    end

    // Pin monitor, RAM write model, scoreboard and watchdog.
    int          rdlow = 0, welow = 0, cehigh = 0, celow = 0;
    logic        prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_ce_n = 1'b1;
    bit          seen_access = 0;
    bit          pend = 0;
    logic [7:0]  p_idx;
    logic [15:0] p_data;
    logic [1:0]  p_ben;
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[i] <= init_word(i);
        end else begin
            // write commit at the end of the pulse
            if (!mem_ce_n && !mem_we_n) begin
                pend   <= 1'b1;
                p_idx  <= mem_addr[7:0];
                p_data <= mem_dq_out;
                p_ben  <= mem_byte_n;
            end else if (pend) begin
                pend <= 1'b0;
                for (int i = 0; i < 2; i++)
                    if (!p_ben[i]) ram[p_idx][i*8 +: 8] <= p_data[i*8 +: 8];
            end
            // read window
            if (!mem_ce_n && !mem_oe_n) begin
                if (rdlow == 0)
                    check(prev_dq_oe == 1'b0 && prev_oe_n == 1'b1, "R2 setup cycle",
                          {prev_dq_oe, prev_oe_n}, 2'b01);
                rdlow++;
            end else if (rdlow > 0) begin
                check(rdlow == RD_CYC, "R2 read window", rdlow, RD_CYC);
                rdlow = 0;
            end
            // write pulse
            if (!mem_we_n) begin
                if (welow == 0) begin
                    check(mem_byte_n == ~cur_be, "R8 byte strobes", mem_byte_n, ~cur_be);
                    check(mem_oe_n == 1'b1, "R9 oe high in write", mem_oe_n, 1);
                    check(mem_dq_oe == 1'b1, "R5 bus driven", mem_dq_oe, 1);
                end
                welow++;
            end else if (welow > 0) begin
                check(welow == WP_CYC, "R4 write pulse", welow, WP_CYC);
                welow = 0;
            end
            // chip enable gap and hold cap
            if (mem_ce_n) begin
                if (!prev_ce_n) begin
                    check(celow < CAP_CYC, "R11 ce hold", celow, CAP_CYC - 1);
                    celow = 0;
                end
                cehigh++;
            end else begin
                if (prev_ce_n && seen_access)
                    check(cehigh >= GAP_CYC, "R7 ce gap", cehigh, GAP_CYC);
                seen_access = 1;
                cehigh = 0;
                celow++;
            end
            prev_oe_n  = mem_oe_n;
            prev_dq_oe = mem_dq_oe;
            prev_ce_n  = mem_ce_n;
            // scoreboard
            if (ack) begin
                if (q.size() == 0) begin
                    check(0, "R10 unexpected ack", 1, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    if (it.wr) begin
                        check(cyc - int'(it.issue) == WR_LAT, "R6 write ack latency",
                              cyc - int'(it.issue), WR_LAT);
                    end else begin
                        check(cyc - int'(it.issue) == RD_LAT, "R3 read ack latency",
                              cyc - int'(it.issue), RD_LAT);
                        check(rdata == it.exp, "R3 R8 read data", rdata, it.exp);
                    end
                end
            end
        end
        if (cyc > 60000) begin
            check(0, "watchdog", cyc, 60000);
            finish_run();
        end
    end

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_req(input bit wr, input logic [19:0] a,
                          input logic [15:0] d, input logic [1:0] be);
        item_t       it;
        logic [15:0] e;
        @(negedge clk);
        e = '0;
        for (int i = 0; i < 2; i++) begin
            if (wr && be[i]) shadow[a[7:0]][i*8 +: 8] = d[i*8 +: 8];
            if (!wr && be[i]) e[i*8 +: 8] = shadow[a[7:0]][i*8 +: 8];
        end
        it.wr = wr; it.exp = e; it.issue = cyc;
        q.push_back(it);
        cur_be    = be;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = init_word(i);
        repeat (4) @(negedge clk);
        // R1: idle pins during reset
        check(mem_ce_n && mem_oe_n && mem_we_n && mem_byte_n == 2'b11 && !mem_dq_oe && !ack,
              "R1 reset pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_byte_n, mem_dq_oe, ack}, 7'b1111100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ack,
              "R1 idle after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 5'b11100);

        do_req(0, 20'h00010, 16'h0, 2'b11);          // R3 untouched word
        do_req(1, 20'h00010, 16'hAAAA, 2'b11);       // R4 R6 full write
        do_req(0, 20'h00010, 16'h0, 2'b11);
        do_req(1, 20'hABC20, 16'h1234, 2'b01);       // R8 lower lane only
        do_req(0, 20'hABC20, 16'h0, 2'b11);
        do_req(1, 20'h00030, 16'hBEEF, 2'b10);       // R8 upper lane only
        do_req(0, 20'h00030, 16'h0, 2'b10);          // R8 lower read lane zero
        do_req(1, 20'h00040, 16'hFFFF, 2'b00);       // R8 mask 00 changes nothing
        do_req(0, 20'h00040, 16'h0, 2'b11);
        do_req(0, 20'hFFFF0, 16'h0, 2'b01);

        // R10: a request pulsed while a read is running is dropped
        begin
            item_t it;
            @(negedge clk);
            it.wr = 0; it.exp = shadow[8'h50]; it.issue = cyc;
            q.push_back(it);
            cur_be = 2'b11;
            req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00050; req_be = 2'b11;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00050;
            req_wdata = 16'h7777; req_be = 2'b11;
            @(negedge clk);
            req_valid = 1'b0;
            wait_idle();
        end
        do_req(0, 20'h00050, 16'h0, 2'b11);          // R10 content unchanged

        for (int k = 0; k < 12; k++) begin
            logic [19:0] a;
            a = {4'(k), 8'h00, 8'(k * 17 + 3)};
            do_req(1, a, 16'(k * 4099 + 1), 2'(k % 4));
            do_req(0, a, 16'h0, 2'b11);
        end

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R10 pending items", q.size(), 0);
        finish_run();
    end

endmodule